// File: doc/BRIEF.md
# Control-flow history fingerprint register

This block keeps a running fingerprint of recent taken control flow for a branch predictor. For every retired branch that qualifies, the 58-bit history moves up by two bit positions. A fixed scatter of low source-address and destination-address bits is then XORed into its bottom sixteen bits. Lookup logic that sits beside the block hashes the result with a branch address, so two paths that reach the same indirect branch by different routes can be told apart.

The retire stage drives the block with one strobe per cycle. With the strobe it gives a branch-kind code, the address of the branch's final byte and the branch's destination. The kind code decides whether the history moves at all. Because of the two-bit shift, each branch's contribution drifts upward and leaves the register after 29 more updates. The current history is always available on the output.

Top module: `ctrl_flow_history`

## Requirements
- R1: `rst_i` is synchronous and active high. While it is high at a rising edge, the history becomes all zeros on that edge, whatever it held before.
- R2: On a qualifying update the next history is the old history shifted left by two, with zeros entering bits [1:0] and the top two bits lost, XORed with a 16-bit mix in bits [15:0]. Bits [57:16] take only shifted bits.
- R3: Destination bits [5:0] are XORed into history bits [5:0] of the mix.
- R4: Source-address bit pairs are XORed into the mix at these positions: source [7:6] into [1:0], [11:10] into [3:2], [15:14] into [5:4], [5:4] into [7:6], [9:8] into [9:8], [13:12] into [11:10], [17:16] into [13:12] and [19:18] into [15:14].
- R5: Source bits above 19, source bits [3:0] and destination bits above 5 have no effect on the history.
- R6: These `kind_i` codes update the history in exactly the same way: 0 (unconditional jump), 1 (taken conditional branch), 3 (call) and 4 (return).
- R7: These `kind_i` codes leave the history unchanged: 2 (not-taken conditional branch), 5 (interrupt return) and the reserved codes 6 and 7.
- R8: While `valid_i` is low, the history holds its value.
- R9: A branch's contribution can still be seen after 25 further updates, and it is fully gone after 29 further updates.
- R10: One update is taken per cycle. Strobes in consecutive cycles are each applied, and each result appears on `hist_o` after the rising edge at which it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | A retired branch is presented this cycle |
| kind_i | input | 3 | Branch-kind code |
| src_addr_i | input | ADDR_W (64) | Address of the branch instruction's final byte |
| dst_addr_i | input | ADDR_W (64) | Branch destination address |
| hist_o | output | HIST_W (58) | Current history value |

## Verification
The bench sets each of the eight source-bit pairs alone, and then the six destination bits. A design that routed a pair to the wrong position, or that mixed the destination into the wrong bits, would show a single wrong bit pair. Upper address bits are driven as all ones with zero low bits, and then under a known low pattern. A design that let those bits leak would show a history that is not zero, or that differs from the model. Every kind code is driven against a known history. A design that updated on a not-taken branch, an interrupt return or a reserved code would move the history, and one that treated calls or returns unlike jumps would give a different value. An aging run follows a full-width contribution through 25 and then 29 zero-address updates, which catches shifts of the wrong amount or in the wrong direction. Consecutive strobes then catch a design that drops a strobe or is a cycle late.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

    localparam int SHIFT_BITS = 2;
    localparam int MIX_W      = 16;
    localparam int SRC_PAIRS  = MIX_W / SHIFT_BITS;
    localparam int DST_BITS   = 6;
    localparam int ADDR_USED  = 20;

    typedef enum logic [2:0] {
        KIND_JUMP     = 3'd0,
        KIND_COND_TK  = 3'd1,
        KIND_COND_NT  = 3'd2,
        KIND_CALL     = 3'd3,
        KIND_RET      = 3'd4,
        KIND_INT_RET  = 3'd5,
        KIND_RSVD6    = 3'd6,
        KIND_RSVD7    = 3'd7
    } br_kind_e;

    // Lowest source bit of the pair that lands on mix bits [2k+1:2k]
    function automatic int src_pair_lsb(input int k);
        case (k)
            0:       return 6;
            1:       return 10;
            2:       return 14;
            3:       return 4;
            4:       return 8;
            5:       return 12;
            6:       return 16;
            default: return 18;
        endcase
    endfunction

endpackage

// File: rtl/bhr_kind_filter.sv
module bhr_kind_filter
    import bhr_pkg::*;
(
    input  logic       valid_i,
    input  logic [2:0] kind_i,
    output logic       upd_o
);
    br_kind_e kind;

    always_comb begin
        kind  = br_kind_e'(kind_i);
        upd_o = 1'b0;
        if (valid_i) begin
            case (kind)
                KIND_JUMP, KIND_COND_TK, KIND_CALL, KIND_RET: upd_o = 1'b1;
                default:                                      upd_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bhr_addr_mix.sv
module bhr_addr_mix
    import bhr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    output logic [MIX_W-1:0]  mix_o
);
    logic [MIX_W-1:0] src_part;
    logic [MIX_W-1:0] dst_part;
    logic             unused_addr_bits;

    for (genvar k = 0; k < SRC_PAIRS; k++) begin : g_pair
        localparam int SL = src_pair_lsb(k);
        assign src_part[SHIFT_BITS*k +: SHIFT_BITS] = src_i[SL +: SHIFT_BITS];
    end

    assign dst_part = {{(MIX_W-DST_BITS){1'b0}}, dst_i[DST_BITS-1:0]};
    assign mix_o    = src_part ^ dst_part;

    assign unused_addr_bits = ^{src_i[ADDR_W-1:ADDR_USED], src_i[3:0],
                                dst_i[ADDR_W-1:DST_BITS]};
endmodule

// File: rtl/ctrl_flow_history.sv
module ctrl_flow_history
    import bhr_pkg::*;
#(
    parameter int HIST_W = 58,
    parameter int ADDR_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    output logic [HIST_W-1:0] hist_o
);
    localparam int PAD_W = HIST_W - MIX_W;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } state_t;

    state_t           st_d, st_q;
    logic             upd;
    logic [MIX_W-1:0] mix;

    bhr_kind_filter u_filter (
        .valid_i (valid_i),
        .kind_i  (kind_i),
        .upd_o   (upd)
    );

    bhr_addr_mix #(.ADDR_W(ADDR_W)) u_mix (
        .src_i (src_addr_i),
        .dst_i (dst_addr_i),
        .mix_o (mix)
    );

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.hist = {st_q.hist[HIST_W-SHIFT_BITS-1:0], {SHIFT_BITS{1'b0}}}
                        ^ {{PAD_W{1'b0}}, mix};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign hist_o = st_q.hist;
endmodule

// File: rtl/bhr_checker.sv
module bhr_checker #(
    parameter int HIST_W = 58
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_i,
    input logic [2:0]        kind_i,
    input logic [HIST_W-1:0] hist_o
);
    logic moving_kind;
    assign moving_kind = (kind_i == 3'd0) || (kind_i == 3'd1) ||
                         (kind_i == 3'd3) || (kind_i == 3'd4);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk_i)
        rst_i |=> (hist_o == '0));

    // R2
    a_r2_upper_shift: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && moving_kind) |=> (hist_o[HIST_W-1:16] == $past(hist_o[HIST_W-3:14])));

    // R7
    a_r7_kind_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !moving_kind) |=> $stable(hist_o));

    // R8
    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(hist_o));
endmodule

bind ctrl_flow_history bhr_checker #(.HIST_W(HIST_W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .valid_i (valid_i),
    .kind_i  (kind_i),
    .hist_o  (hist_o)
);

// File: tb/ctrl_flow_history_tb_top.sv
`timescale 1ns/1ps
module ctrl_flow_history_tb_top;
    localparam int HW = 58;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [2:0]    kind = 3'd0;
    logic [AW-1:0] src = '0;
    logic [AW-1:0] dst = '0;
    logic [HW-1:0] hist;
    logic [HW-1:0] exp_h = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ctrl_flow_history #(.HIST_W(HW), .ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .kind_i(kind),
        .src_addr_i(src), .dst_addr_i(dst), .hist_o(hist)
    );

    function automatic logic [HW-1:0] model(input logic [HW-1:0] h,
                                            input logic [AW-1:0] s,
                                            input logic [AW-1:0] d);
        logic [15:0] m;
        m = 16'h0;
        m[5:0]   = d[5:0];
        m[1:0]   = m[1:0] ^ s[7:6];
        m[3:2]   = m[3:2] ^ s[11:10];
        m[5:4]   = m[5:4] ^ s[15:14];
        m[7:6]   = s[5:4];
        m[9:8]   = s[9:8];
        m[11:10] = s[13:12];
        m[13:12] = s[17:16];
        m[15:14] = s[19:18];
        return {h[HW-3:0], 2'b00} ^ {{(HW-16){1'b0}}, m};
    endfunction

    function automatic bit moves(input logic [2:0] k);
        return (k == 3'd0) || (k == 3'd1) || (k == 3'd3) || (k == 3'd4);
    endfunction

    task automatic check(input string req, input logic [HW-1:0] act,
                         input logic [HW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // one branch per cycle; inputs change at negedge, output read a cycle later
    task automatic step(input string req, input logic [2:0] k,
                        input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input bit do_check);
        valid = 1'b1; kind = k; src = s; dst = d;
        @(negedge clk);
        if (moves(k)) exp_h = model(exp_h, s, d);
        valid = 1'b0;
        if (do_check) check(req, hist, exp_h);
    endtask

    task automatic do_reset();
        rst = 1'b1; valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_h = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 initial", hist, '0);
        step("R1 fill", 3'd0, 64'hFFFFF, 64'h3F, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_h = '0;
        check("R1 mid-run", hist, '0);
    endtask

    task automatic t_dst_bits();
        do_reset();
        step("R3 dst all ones", 3'd0, '0, 64'h3F, 1'b1);
        check("R3 dst literal", hist, 58'h3F);
        do_reset();
        step("R3 dst bit5", 3'd0, '0, 64'h20, 1'b1);
    endtask

    task automatic t_src_pairs();
        logic [AW-1:0] s;
        for (int k = 0; k < 8; k++) begin
            do_reset();
            s = '0;
            case (k)
                0: s[7:6] = 2'b11;   1: s[11:10] = 2'b11;
                2: s[15:14] = 2'b11; 3: s[5:4] = 2'b11;
                4: s[9:8] = 2'b11;   5: s[13:12] = 2'b11;
                6: s[17:16] = 2'b11; default: s[19:18] = 2'b11;
            endcase
            step("R4 source pair", 3'd0, s, '0, 1'b1);
        end
        do_reset();
        step("R4 src into dst xor", 3'd0, 64'h40, 64'h01, 1'b1);
        check("R4 cancel literal", hist, '0);
    endtask

    task automatic t_high_bits();
        do_reset();
        step("R5 high bits only", 3'd1, 64'hFFFF_FFFF_FFF0_000F, 64'hFFFF_FFFF_FFFF_FFC0, 1'b1);
        check("R5 zero literal", hist, '0);
        step("R5 with low bits", 3'd3, 64'hDEAD_BEEF_A5A5_A5A5, 64'h1234_5678_9ABC_DEF7, 1'b1);
    endtask

    task automatic t_kinds();
        logic [HW-1:0] first;
        do_reset();
        step("R6 jump", 3'd0, 64'h3C5A0, 64'h2B, 1'b1);
        first = hist;
        do_reset();
        step("R6 cond taken", 3'd1, 64'h3C5A0, 64'h2B, 1'b1);
        check("R6 taken==jump", hist, first);
        do_reset();
        step("R6 call", 3'd3, 64'h3C5A0, 64'h2B, 1'b1);
        check("R6 call==jump", hist, first);
        do_reset();
        step("R6 return", 3'd4, 64'h3C5A0, 64'h2B, 1'b1);
        check("R6 ret==jump", hist, first);
        step("R7 not taken", 3'd2, 64'hFFFFF, 64'h3F, 1'b1);
        step("R7 interrupt return", 3'd5, 64'hFFFFF, 64'h3F, 1'b1);
        step("R7 reserved 6", 3'd6, 64'hFFFFF, 64'h3F, 1'b1);
        step("R7 reserved 7", 3'd7, 64'hFFFFF, 64'h3F, 1'b1);
        check("R7 held", hist, first);
    endtask

    task automatic t_idle();
        do_reset();
        step("R8 setup", 3'd0, 64'h9_1234, 64'h15, 1'b1);
        src = 64'hFFFFF; dst = 64'h3F; kind = 3'd0; valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 idle hold", hist, exp_h);
    endtask

    task automatic t_aging();
        do_reset();
        step("R9 seed", 3'd0, 64'hFFFF0, 64'h3F, 1'b1);
        for (int i = 0; i < 25; i++) step("R9 age", 3'd0, '0, '0, 1'b0);
        check("R9 after 25", hist, exp_h);
        checks++;
        if (hist == '0) begin
            errors++;
            $display("FAIL R9 visible actual=%h expected=nonzero", hist);
        end
        for (int i = 0; i < 4; i++) step("R9 age", 3'd0, '0, '0, 1'b0);
        check("R9 gone after 29", hist, '0);
    endtask

    task automatic t_back2back();
        do_reset();
        for (int i = 0; i < 12; i++)
            step("R10 consecutive", 3'(i % 5), 64'(32'h1_3579 * (i + 1)),
                 64'(i * 7 + 3), 1'b1);
        check("R2 consecutive final", hist, exp_h);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_dst_bits();
        t_src_pairs();
        t_high_bits();
        t_kinds();
        t_idle();
        t_aging();
        t_back2back();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule